// File: doc/BRIEF.md
# System clock source switch controller

This block picks the system clock from two free-running sources: an oscillator clock and a PLL clock. A select bit, written through a small configuration port in the oscillator domain, chooses the PLL when it is one and the oscillator when it is zero. A self-clock request input overrides the bit and forces the PLL path. The block also drives the PLL enable. A request to switch that enable off is refused while the PLL is wanted or is still running as the source.

Each source has its own enable chain. The chain is a synchronizer clocked on the falling edge of that source. The old source's enable must be seen low before the new source's enable can rise, so the system clock holds still between the last edge of one source and the first edge of the other. While a switch is under way, a busy flag is set and later requests wait. A bus clock at half the system clock rate comes from a toggle flop clocked by the system clock, so the bus clock also freezes during a switch.

Top module: `clk_src_switch`

## Requirements
- R1: A configuration write (`cfg_we` high at a rising edge of `osc_clk`) with `cfg_sel`=1 makes the PLL clock the system clock. With `cfg_sel`=0, and no self-clock request, the source is the oscillator clock.
- R2: While the PLL is wanted (the stored select bit is 1, or `scm_req` is high) or is still the active source, a write with `cfg_pll_on`=0 leaves the stored PLL-on bit unchanged and `pll_enable` stays 1. In every other case a write stores `cfg_pll_on`. `pll_enable` is the PLL-on bit OR the select bit OR `scm_req`.
- R3: A select change finishes within 4 oscillator periods plus 4 PLL periods, counted from the rising edge of `osc_clk` that captures the write.
- R4: The two source enables are never high together. `sys_clk` has no high or low pulse shorter than half the faster source period.
- R5: While `scm_req` is high, the system clock is the PLL clock, whatever the value of the select bit.
- R6: `bus_clk` toggles on every rising edge of `sys_clk`, so its period is twice the system clock period.
- R7: While `rst_n` is low, the oscillator drives `sys_clk`, and `pll_enable`, `switch_busy` and `bus_clk` are all 0.
- R8: `switch_busy` is 1 from the `osc_clk` edge at which the wanted source changes until the new source's enable is high and the old one is low. Once it clears, exactly one enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; also clocks the configuration port |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Select bit written: 1 = PLL, 0 = oscillator |
| cfg_pll_on | input | 1 | PLL-on bit written |
| scm_req | input | 1 | Self-clock request, oscillator domain, forces PLL |
| sys_clk | output | 1 | Glitch-free system clock |
| bus_clk | output | 1 | System clock divided by two |
| pll_enable | output | 1 | Enable to the PLL |
| switch_busy | output | 1 | Source change in progress |

## Verification
The stored select bit and the PLL-on bit settle one `osc_clk` edge after a write. The bench samples `switch_busy` 1 ns after that edge and expects it to be high. It then waits for busy to clear and checks that the elapsed time fits the R3 budget of 40 ns, which is 4 × 4 ns plus 4 × 6 ns. The clock source is checked only after thirty oscillator cycles of settling, by timing two successive `sys_clk` rising edges. Bus-clock values are sampled 0.5 ns after a `sys_clk` rising edge. The shortest `sys_clk` pulse seen over the whole run is checked at the end.

// File: rtl/clk_src_switch_pkg.sv
`timescale 1ns/1ps
package clk_src_switch_pkg;
   typedef enum logic {SRC_OSC = 1'b0, SRC_PLL = 1'b1} clk_src_e;
   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/css_ctrl.sv
`timescale 1ns/1ps
module css_ctrl
   import clk_src_switch_pkg::*;
(
   input  logic     osc_clk,
   input  logic     rst_n,
   input  logic     cfg_we,
   input  logic     cfg_sel,
   input  logic     cfg_pll_on,
   input  logic     scm_req,
   input  logic     osc_en,
   input  logic     pll_en,
   output clk_src_e target,
   output logic     busy,
   output logic     pll_enable
);
   logic     sel_q;
   logic     pllon_q;
   clk_src_e target_q;
   clk_src_e want;
   logic     settled;
   logic     pll_needed;

   assign want       = (sel_q | scm_req) ? SRC_PLL : SRC_OSC;
   assign settled    = (target_q == SRC_PLL) ? (pll_en & ~osc_en) : (osc_en & ~pll_en);
   assign busy       = (want != target_q) | ~settled;
   assign pll_needed = (want == SRC_PLL) | (target_q == SRC_PLL);
   assign pll_enable = pllon_q | pll_needed;
   assign target     = target_q;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         pllon_q  <= 1'b0;
         target_q <= SRC_OSC;
      end else begin
         if (cfg_we) begin
            sel_q <= cfg_sel;
            if (cfg_pll_on || !pll_needed) pllon_q <= cfg_pll_on;
         end
         if (settled) target_q <= want;
      end
   end

   assert_sel_capture_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      cfg_we |=> (sel_q == $past(cfg_sel)));

   assert_pll_off_blocked_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
      (cfg_we && !cfg_pll_on && (sel_q || scm_req || target_q == SRC_PLL)) |=> (pll_enable && pllon_q == $past(pllon_q)));
endmodule

// File: rtl/css_en_sync.sv
`timescale 1ns/1ps
module css_en_sync
   import clk_src_switch_pkg::*;
#(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic other_en,
   output logic en
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
         $error("css_en_sync: STAGES below minimum");
      end
   endgenerate

   logic [LAST:0] chain;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= req & ~other_en;
   end

   genvar gi;
   generate
      for (gi = 1; gi < STAGES; gi++) begin : g_stage
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= RST_VAL;
            else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign en = chain[LAST];

   assert_break_before_make_R4: assert property (@(negedge clk) disable iff (!rst_n)
      $rose(en) |-> !other_en);
endmodule

// File: rtl/css_bus_div.sv
`timescale 1ns/1ps
module css_bus_div (
   input  logic sys_clk,
   input  logic rst_n,
   output logic bus_clk
);
   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) bus_clk <= 1'b0;
      else        bus_clk <= ~bus_clk;
   end
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
   import clk_src_switch_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic pll_clk,
   input  logic rst_n,
   input  logic cfg_we,
   input  logic cfg_sel,
   input  logic cfg_pll_on,
   input  logic scm_req,
   output logic sys_clk,
   output logic bus_clk,
   output logic pll_enable,
   output logic switch_busy
);
   clk_src_e target;
   logic     osc_en;
   logic     pll_en;

   css_ctrl u_ctrl (
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_pll_on (cfg_pll_on),
      .scm_req    (scm_req),
      .osc_en     (osc_en),
      .pll_en     (pll_en),
      .target     (target),
      .busy       (switch_busy),
      .pll_enable (pll_enable)
   );

   css_en_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_osc_sync (
      .clk      (osc_clk),
      .rst_n    (rst_n),
      .req      (target == SRC_OSC),
      .other_en (pll_en),
      .en       (osc_en)
   );

   css_en_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_sync (
      .clk      (pll_clk),
      .rst_n    (rst_n),
      .req      (target == SRC_PLL),
      .other_en (osc_en),
      .en       (pll_en)
   );

   assign sys_clk = (osc_clk & osc_en) | (pll_clk & pll_en);

   css_bus_div u_div (
      .sys_clk (sys_clk),
      .rst_n   (rst_n),
      .bus_clk (bus_clk)
   );

   always_comb begin
      assert_enables_exclusive_R4: assert (!(osc_en && pll_en));
   end

   assert_done_single_source_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(switch_busy) |-> (osc_en ^ pll_en));
endmodule

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;
   logic osc_clk = 1'b0;
   logic pll_clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_sel = 1'b0, cfg_pll_on = 1'b0, scm_req = 1'b0;
   logic sys_clk, bus_clk, pll_enable, switch_busy;

   int checks = 0;
   int failures = 0;
   bit sel_m = 0, pon_m = 0, scm_m = 0;
   real min_w = 1000.0;
   real last_edge = -1.0;
   real tw;

   always #2 osc_clk = ~osc_clk;
   initial begin
      #1.3;
      forever #3 pll_clk = ~pll_clk;
   end

   clk_src_switch dut (
      .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_pll_on(cfg_pll_on), .scm_req(scm_req),
      .sys_clk(sys_clk), .bus_clk(bus_clk), .pll_enable(pll_enable), .switch_busy(switch_busy)
   );

   always @(sys_clk) begin
      if (last_edge >= 0.0 && ($realtime - last_edge) < min_w) min_w = $realtime - last_edge;
      last_edge = $realtime;
   end

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_period(input bit s, input bit m);
      return (s | m) ? 6 : 4;
   endfunction

   function automatic bit exp_pll_en(input bit p, input bit s, input bit m);
      return p | s | m;
   endfunction

   task automatic measure(output int per);
      real t0;
      @(posedge sys_clk); t0 = $realtime;
      @(posedge sys_clk);
      per = int'($realtime - t0 + 0.01);
   endtask

   task automatic write_cfg(input bit s, input bit p);
      @(negedge osc_clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_pll_on = p;
      @(posedge osc_clk);
      tw = $realtime;
      if (!(p == 1'b0 && (sel_m || scm_m))) pon_m = p;
      sel_m = s;
      #1 cfg_we = 1'b0;
   endtask

   task automatic settle();
      repeat (30) @(negedge osc_clk);
   endtask

   task automatic check_state(input string req);
      int per;
      check({req, " busy idle"}, switch_busy, 0);
      measure(per);
      check({req, " period"}, per, exp_period(sel_m, scm_m));
      check({req, " pll_enable"}, pll_enable, exp_pll_en(pon_m, sel_m, scm_m));
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int per;
      bit b0;
      int unsigned seed;
      seed = $urandom(32'h5eed);

      // R7: reset state
      repeat (5) @(negedge osc_clk);
      check("R7 pll_enable", pll_enable, 0);
      check("R7 busy", switch_busy, 0);
      check("R7 bus_clk", bus_clk, 0);
      measure(per);
      check("R7 osc period", per, 4);
      @(negedge osc_clk); rst_n = 1'b1;
      settle();
      check_state("R1 osc");

      // R1, R3, R8: switch to PLL
      write_cfg(1, 1);
      check("R8 busy set", switch_busy, 1);
      wait (switch_busy == 1'b0);
      check("R3 switch time", ($realtime - tw) <= 40.0, 1);
      settle();
      check_state("R1 pll");

      // R6: bus clock divides by two
      @(posedge sys_clk); #0.5 b0 = bus_clk;
      @(posedge sys_clk); #0.5;
      check("R6 toggle", bus_clk, !b0);
      begin
         real t0;
         @(posedge bus_clk); t0 = $realtime;
         @(posedge bus_clk);
         check("R6 bus period", int'($realtime - t0 + 0.01), 12);
      end

      // R2: PLL-off refused while PLL selected
      write_cfg(1, 0);
      #1 check("R2 hold on", pll_enable, 1);
      write_cfg(0, 0);
      check("R8 busy back", switch_busy, 1);
      wait (switch_busy == 1'b0);
      check("R3 switch back time", ($realtime - tw) <= 40.0, 1);
      settle();
      check_state("R2 still on");
      write_cfg(0, 0);
      settle();
      check_state("R2 cleared");

      // R5: self-clock forces PLL
      @(negedge osc_clk); scm_req = 1'b1; scm_m = 1'b1;
      settle();
      check_state("R5 scm forced");
      write_cfg(0, 0);
      settle();
      check_state("R5 sel ignored");
      @(negedge osc_clk); scm_req = 1'b0; scm_m = 1'b0;
      settle();
      check_state("R5 released");

      // random mix
      for (int i = 0; i < 16; i++) begin
         bit s, p, m;
         s = 1'($urandom % 2); p = 1'($urandom % 2); m = 1'($urandom % 2);
         @(negedge osc_clk); scm_req = m; scm_m = m;
         settle();
         write_cfg(s, p);
         settle();
         check_state("R1 R2 R5 random");
      end

      check("R4 min pulse ok", min_w >= 1.9, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule